// File: doc/BRIEF.md
# Repeater KSV List and Topology Handoff Port

This block sits between the downstream side of a content-protection repeater and the receiver core that answers the upstream transmitter. Downstream logic acts as producer. Through a 32-bit register slave it loads a list of key selection vector bytes and a 16-bit topology word, then marks them valid. The receiver core acts as consumer. It asks for fresh data when upstream authentication restarts, reads the buffered bytes by index once they are valid, and pulses a consumed strobe when it has finished.

The handoff uses three flags. The consumer's request raises both REQUEST and READY. A producer write that sets VALID locks the data and drops READY and REQUEST. The consumer's consumed strobe clears VALID, empties the list and raises READY again. A separate register holds the repeater-mode bit that the receiver side uses to report whether it is an endpoint.

Top module: `rpt_msg_port`

## Requirements
- R1: After reset, address 1 and address 2 read 0, core_valid is 0, core_len is 0 and repeater_mode is 0.
- R2: Each bus write to address 0 appends wdata[7:0] to the list, in arrival order. The first byte written is the most significant byte of the first KSV. core_len counts the bytes written. core_rdata returns the byte at index core_raddr one cycle after the index is presented.
- R3: The list holds MAX_KSV*5 bytes (635 by default). Writes to address 0 beyond that count are ignored and core_len stays at the maximum.
- R4: A core_req pulse while VALID is 0 sets REQUEST (address 1 bit 18) and READY (bit 17). REQUEST is never 1 while READY is 0.
- R5: A bus write to address 1 while VALID is 0 stores wdata[15:0] as the topology word, with bits 15:12 forced to 0. If wdata[16] is 1, the same write sets VALID (bit 16) and clears READY and REQUEST. core_topo shows the stored word.
- R6: While VALID is 1, the list, the topology word and the flags ignore bus writes to address 0, bus writes to address 1 and core_req.
- R7: core_consumed while VALID is 1 clears VALID, empties the list (core_len becomes 0) and sets READY. The topology word is kept. core_consumed while VALID is 0 has no effect.
- R8: Address 2 bit 0 is a read/write repeater-mode bit that drives repeater_mode. Bits 31:1 of address 2 read 0.
- R9: Address 0 and address 3 read 0, and bits 31:19 of address 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| core_req | input | 1 | Consumer asks for a new list and topology word |
| core_consumed | input | 1 | Consumer has finished reading |
| core_raddr | input | CNT_W | List byte index to read |
| core_rdata | output | 8 | List byte at the index |
| core_valid | output | 1 | VALID flag |
| core_len | output | CNT_W | Number of list bytes held |
| core_topo | output | 16 | Stored topology word |
| repeater_mode | output | 1 | Repeater-mode bit |

## Verification
The bench attacks the lock window. It writes list bytes, topology words and core_req while VALID is set. A design that failed to gate these would show a grown core_len or a changed address 1 word. It also fills the list past capacity, where a missing bound would wrap the count or overwrite early bytes. It issues consumed without VALID, where a careless design would raise READY or clear the list. It writes a topology word with its reserved nibble set, where a design that skipped the mask would read those bits back. Finally, it checks that the first byte read back is the first byte written, which catches a reversed or shifted list.

// File: rtl/rpt_msg_pkg.sv
package rpt_msg_pkg;
   localparam int unsigned REG_LIST = 0;
   localparam int unsigned REG_HSK  = 1;
   localparam int unsigned REG_MODE = 2;
   localparam int unsigned BIT_REQ  = 18;
   localparam int unsigned BIT_RDY  = 17;
   localparam int unsigned BIT_VLD  = 16;
   localparam logic [15:0] TOPO_MASK = 16'h0FFF;
   localparam int unsigned KSV_BYTES = 5;
endpackage

// File: rtl/rpt_hsk.sv
module rpt_hsk (
   input  logic clk,
   input  logic rst_n,
   input  logic set_valid,
   input  logic core_req,
   input  logic core_consumed,
   output logic valid_o,
   output logic ready_o,
   output logic request_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o   <= 1'b0;
         ready_o   <= 1'b0;
         request_o <= 1'b0;
      end else if (valid_o) begin
         if (core_consumed) begin
            valid_o   <= 1'b0;
            ready_o   <= 1'b1;
            request_o <= 1'b0;
         end
      end else if (set_valid) begin
         valid_o   <= 1'b1;
         ready_o   <= 1'b0;
         request_o <= 1'b0;
      end else if (core_req) begin
         request_o <= 1'b1;
         ready_o   <= 1'b1;
      end
   end

   // R4
   req_implies_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      request_o |-> ready_o);
   // R5
   valid_excl_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !ready_o);
   // R7
   consume_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && core_consumed) |=> (!valid_o && ready_o));
   // R6
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !core_consumed) |=> valid_o);
endmodule

// File: rtl/rpt_ksv_buf.sv
module rpt_ksv_buf #(
   parameter int unsigned DEPTH  = 635,
   parameter int unsigned CNT_W  = 10,
   parameter bit          RD_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [7:0]       wbyte,
   input  logic             clr,
   input  logic [CNT_W-1:0] raddr,
   output logic [7:0]       rbyte,
   output logic [CNT_W-1:0] count
);
   logic [7:0] mem [DEPTH];
   logic       full;
   logic [7:0] rd_sel;

   assign full = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (wr && !full) count <= count + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr && !full && !clr) mem[count] <= wbyte;
   end

   assign rd_sel = (raddr < CNT_W'(DEPTH)) ? mem[raddr] : 8'h00;

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) rbyte <= 8'h00;
            else        rbyte <= rd_sel;
         end
      end else begin : g_rd_comb
         assign rbyte = rd_sel;
      end
   endgenerate

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R7
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr) |=> full);
endmodule

// File: rtl/rpt_msg_port.sv
module rpt_msg_port
   import rpt_msg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned MAX_KSV    = 127,
   parameter bit          CORE_RD_REG = 1'b1,
   localparam int unsigned LIST_BYTES = MAX_KSV * KSV_BYTES,
   localparam int unsigned CNT_W      = $clog2(LIST_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              core_req,
   input  logic              core_consumed,
   input  logic [CNT_W-1:0]  core_raddr,
   output logic [7:0]        core_rdata,
   output logic              core_valid,
   output logic [CNT_W-1:0]  core_len,
   output logic [15:0]       core_topo,
   output logic              repeater_mode
);
   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("rpt_msg_port: ADDR_W must be at least 2");
      end
      if (MAX_KSV < 1 || MAX_KSV > 127) begin : g_bad_ksv
         $error("rpt_msg_port: MAX_KSV must be 1..127");
      end
   endgenerate

   logic wr_list, wr_hsk, wr_mode;
   logic valid, ready, request;
   logic [15:0] topo_q;
   logic mode_q;

   assign wr_list = bus_wr && (bus_addr == ADDR_W'(REG_LIST)) && !valid;
   assign wr_hsk  = bus_wr && (bus_addr == ADDR_W'(REG_HSK))  && !valid;
   assign wr_mode = bus_wr && (bus_addr == ADDR_W'(REG_MODE));

   rpt_hsk u_hsk (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_valid    (wr_hsk && bus_wdata[BIT_VLD]),
      .core_req     (core_req),
      .core_consumed(core_consumed),
      .valid_o      (valid),
      .ready_o      (ready),
      .request_o    (request)
   );

   rpt_ksv_buf #(
      .DEPTH (LIST_BYTES),
      .CNT_W (CNT_W),
      .RD_REG(CORE_RD_REG)
   ) u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_list),
      .wbyte(bus_wdata[7:0]),
      .clr  (valid && core_consumed),
      .raddr(core_raddr),
      .rbyte(core_rdata),
      .count(core_len)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         topo_q <= 16'h0000;
         mode_q <= 1'b0;
      end else begin
         if (wr_hsk)  topo_q <= bus_wdata[15:0] & TOPO_MASK;
         if (wr_mode) mode_q <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = 32'h0;
      if (bus_addr == ADDR_W'(REG_HSK)) begin
         bus_rdata[15:0]    = topo_q;
         bus_rdata[BIT_VLD] = valid;
         bus_rdata[BIT_RDY] = ready;
         bus_rdata[BIT_REQ] = request;
      end else if (bus_addr == ADDR_W'(REG_MODE)) begin
         bus_rdata[0] = mode_q;
      end
   end

   assign core_valid    = valid;
   assign core_topo     = topo_q;
   assign repeater_mode = mode_q;

   // R6
   topo_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(valid) && valid) |-> $stable(topo_q));
   // R5
   topo_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_topo[15:12] == 4'h0);
endmodule

// File: tb/rpt_msg_port_tb.sv
`timescale 1ns/1ps
module rpt_msg_port_tb;
   localparam int LIST_BYTES = 635;
   localparam int CW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic core_req = 1'b0, core_consumed = 1'b0;
   logic [CW-1:0] core_raddr = '0;
   logic [7:0] core_rdata;
   logic core_valid, repeater_mode;
   logic [CW-1:0] core_len;
   logic [15:0] core_topo;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rpt_msg_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_req(core_req),
      .core_consumed(core_consumed), .core_raddr(core_raddr),
      .core_rdata(core_rdata), .core_valid(core_valid), .core_len(core_len),
      .core_topo(core_topo), .repeater_mode(repeater_mode)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic core_rd(int idx, output logic [7:0] b);
      @(negedge clk);
      core_raddr = CW'(idx);
      @(negedge clk);
      b = core_rdata;
   endtask

   task automatic pulse_req();
      @(negedge clk); core_req = 1'b1;
      @(negedge clk); core_req = 1'b0;
   endtask

   task automatic pulse_consumed();
      @(negedge clk); core_consumed = 1'b1;
      @(negedge clk); core_consumed = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(2'd1, d); chk("R1 hsk reg", d, 32'h0);
      rd(2'd2, d); chk("R1 mode reg", d, 32'h0);
      chk("R1 valid", {31'h0, core_valid}, 32'h0);
      chk("R1 len", {22'h0, core_len}, 32'h0);
      chk("R1 repeater_mode", {31'h0, repeater_mode}, 32'h0);
   endtask

   task automatic t_list();
      logic [31:0] d;
      logic [7:0] b;
      logic [7:0] bytes [7] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'h11, 8'h22};
      pulse_req();
      rd(2'd1, d); chk("R4 request and ready", d, 32'h0006_0000);
      foreach (bytes[i]) wr(2'd0, {24'hFFFFFF, bytes[i]});
      chk("R2 len", {22'h0, core_len}, 32'd7);
      core_rd(0, b); chk("R2 first byte", {24'h0, b}, 32'hA1);
      core_rd(4, b); chk("R2 fifth byte", {24'h0, b}, 32'hE5);
      core_rd(6, b); chk("R2 last byte", {24'h0, b}, 32'h22);
   endtask

   task automatic t_status();
      logic [31:0] d;
      wr(2'd1, 32'hFFF1_F8A5);
      rd(2'd1, d); chk("R5 valid set, flags cleared, mask", d, 32'h0001_08A5);
      chk("R5 core_valid", {31'h0, core_valid}, 32'h1);
      chk("R5 core_topo", {16'h0, core_topo}, 32'h08A5);
      rd(2'd0, d); chk("R9 list addr reads zero", d, 32'h0);
   endtask

   task automatic t_locked();
      logic [31:0] d;
      wr(2'd0, 32'h77);
      chk("R6 list write ignored", {22'h0, core_len}, 32'd7);
      wr(2'd1, 32'h0000_0123);
      rd(2'd1, d); chk("R6 status write ignored", d, 32'h0001_08A5);
      pulse_req();
      rd(2'd1, d); chk("R6 core_req ignored", d, 32'h0001_08A5);
   endtask

   task automatic t_consume();
      logic [31:0] d;
      pulse_consumed();
      rd(2'd1, d); chk("R7 consumed releases", d, 32'h0002_08A5);
      chk("R7 len cleared", {22'h0, core_len}, 32'd0);
      pulse_consumed();
      rd(2'd1, d); chk("R7 stray consumed no effect", d, 32'h0002_08A5);
      wr(2'd1, 32'h0000_0321);
      rd(2'd1, d); chk("R5 status only write", d, 32'h0002_0321);
   endtask

   task automatic t_mode();
      logic [31:0] d;
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, d); chk("R8 mode set", d, 32'h1);
      chk("R8 repeater_mode", {31'h0, repeater_mode}, 32'h1);
      wr(2'd2, 32'h0);
      rd(2'd2, d); chk("R8 mode clear", d, 32'h0);
      rd(2'd3, d); chk("R9 addr3 reads zero", d, 32'h0);
   endtask

   task automatic t_full();
      logic [7:0] b;
      for (int i = 0; i < LIST_BYTES + 3; i++) wr(2'd0, 32'(i & 8'hFF));
      chk("R3 len saturates", {22'h0, core_len}, 32'(LIST_BYTES));
      core_rd(0, b); chk("R3 first byte kept", {24'h0, b}, 32'h00);
      core_rd(LIST_BYTES - 1, b);
      chk("R3 last byte", {24'h0, b}, 32'((LIST_BYTES - 1) & 8'hFF));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_list();
      t_status();
      t_locked();
      t_consume();
      t_mode();
      t_full();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule